// File: doc/BRIEF.md
# Serial Transceiver with Receive Error Status

This block is a full-duplex asynchronous serial port for a host bus. The host writes a byte to the data register, and the transmitter sends it at once as a start bit, the data bits LSB first, an optional parity bit and one or two stop bits. The receiver watches the serial input and checks each frame's parity and stop bit. It places the data in a one-entry receive buffer and records parity, framing and overrun errors in a status register. A separate enable gates each of the two completion interrupt outputs.

All bit timing comes from an external tick that pulses 16 times per bit period, so one bit lasts 16 ticks. The status register is not cleared when it is read. It is cleared when the receive buffer is read, and it is replaced when the next frame completes. An unread buffer therefore turns every later frame into an overrun until the host reads it. While a frame is being sent, the line format is fixed and writes to the mode register have no effect.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, txd is high and both interrupt outputs are low. Status (address 1) reads 0, mode (address 2) reads 0x01 and control (address 3) reads 0. No transmit interrupt and no transmit flag appear until data is written.
- R2: A write to address 0 while the transmitter is idle starts a frame on the next clock. The frame is a low start bit, the data bits LSB first (8 bits if mode bit0 is 1, else 7), then a parity bit if mode bit1 is 1 (even, or odd when mode bit2 is 1), then a high stop bit and a second stop bit if mode bit3 is 1. Each bit lasts 16 ticks. A data write while a frame is being sent is ignored.
- R3: At the end of the last stop bit, control bit2 (transmit flag) is set. If control bit0 is 1, irq_tx also pulses high for one clock. Writing control with bit2 at 1 clears the flag.
- R4: The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge. It then samples each bit every 16 ticks and places the data bits in the buffer, which is read at address 0. In 7-bit mode, bit7 of the buffer reads 0.
- R5: Status bit0 is set when the received parity bit does not match the parity mode set in the mode register.
- R6: Status bit1 is set when the first stop bit is sampled low.
- R7: If a frame completes while the buffer is still unread, status bit2 (overrun) is set and the buffer keeps the older data. Overrun persists on every later frame until the buffer is read.
- R8: Reading address 0 empties the buffer and clears all three status bits. Completion of the next frame replaces bits 0 and 1 with that frame's results.
- R9: irq_rx pulses high for one clock on every completed frame, including frames with errors, while control bit1 is 1. Once control bit1 is cleared, no later frame completion produces a pulse.
- R10: A write to the mode register while a frame is being sent is ignored.
- R11: A low pulse on rxd shorter than half a bit produces no frame, no interrupt and no status change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-clock pulse, 16 per bit period |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; a read at address 0 empties the buffer |
| addr | input | 2 | 0 data, 1 status, 2 mode, 3 control |
| wdata | input | DW | Host write data |
| rdata | output | DW | Read data for addr, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idle high |
| irq_tx | output | 1 | Transmit completion pulse |
| irq_rx | output | 1 | Receive completion pulse |

## Verification
Register reads are combinational, so the bench samples rdata in the same cycle it raises rd_en. The bench checks the effect of a read on the buffer and status in the following cycle. txd goes low one clock after the data write, and every later bit boundary falls 64 clocks apart, given one tick every 4 clocks. For this reason, the bench samples 30 clocks after the write and then every 64 clocks, which puts each sample near the centre of a bit. The receiver's buffer, status and irq_rx change on the clock edge after the stop-bit centre tick, about 32 clocks into the stop bit. The bench therefore reads them only once the whole frame and a bit of idle have passed. Interrupt pulses are counted at every falling clock edge, and the counts are compared once each frame is over.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    // Line format; bit order matches the mode register layout
    typedef struct packed {
        logic two_stop;  // bit3
        logic odd;       // bit2
        logic par_en;    // bit1
        logic len8;      // bit0
    } mode_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } phase_t;

    // Parity bit over up to 16 data bits (unused bits must be zero)
    function automatic logic calc_par(input logic [15:0] bits, input logic odd);
        return (^bits) ^ odd;
    endfunction

endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_xcvr_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  mode_t         mode,
    output logic          busy,
    output logic          txd,
    output logic          done
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW);

    typedef struct packed {
        phase_t        ph;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          pbit;
        logic          extra;
        logic          line;
        logic          done;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic [DW-1:0] mask;
    logic [IW-1:0] last;

    always_comb begin
        mask = mode.len8 ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
        last = mode.len8 ? IW'(DW-1) : IW'(DW-2);
        s_d = s_q;
        s_d.done = 1'b0;
        if (s_q.ph == PH_IDLE) begin
            s_d.line = 1'b1;
            if (start) begin
                s_d.ph   = PH_START;
                s_d.cnt  = '0;
                s_d.sh   = data & mask;
                s_d.pbit = calc_par(16'(data & mask), mode.odd);
                s_d.line = 1'b0;
            end
        end else if (tick) begin
            if (s_q.cnt != CW'(OSR-1)) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                s_d.cnt = '0;
                case (s_q.ph)
                    PH_START: begin
                        s_d.ph   = PH_DATA;
                        s_d.idx  = '0;
                        s_d.line = s_q.sh[0];
                    end
                    PH_DATA: begin
                        if (s_q.idx == last) begin
                            if (mode.par_en) begin
                                s_d.ph   = PH_PAR;
                                s_d.line = s_q.pbit;
                            end else begin
                                s_d.ph    = PH_STOP;
                                s_d.line  = 1'b1;
                                s_d.extra = mode.two_stop;
                            end
                        end else begin
                            s_d.idx  = s_q.idx + 1'b1;
                            s_d.sh   = s_q.sh >> 1;
                            s_d.line = s_q.sh[1];
                        end
                    end
                    PH_PAR: begin
                        s_d.ph    = PH_STOP;
                        s_d.line  = 1'b1;
                        s_d.extra = mode.two_stop;
                    end
                    PH_STOP: begin
                        if (s_q.extra) begin
                            s_d.extra = 1'b0;
                        end else begin
                            s_d.ph   = PH_IDLE;
                            s_d.done = 1'b1;
                        end
                    end
                    default: s_d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.ph != PH_IDLE);
    assign txd  = s_q.line;
    assign done = s_q.done;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_xcvr_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  mode_t         mode,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(DW);
    localparam int MID = OSR/2 - 1;

    typedef struct packed {
        phase_t        ph;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic [DW-1:0] data;
        logic          perr;
        logic          ferr;
        logic          done;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic [IW-1:0] last;
    logic [DW-1:0] aligned;

    always_comb begin
        last    = mode.len8 ? IW'(DW-1) : IW'(DW-2);
        aligned = mode.len8 ? s_q.sh : (s_q.sh >> 1);
        s_d = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (tick && !rxd) begin
                    s_d.ph  = PH_START;
                    s_d.cnt = '0;
                end
            end
            PH_START: begin
                if (tick) begin
                    if (s_q.cnt == CW'(MID)) begin
                        if (!rxd) begin
                            s_d.ph   = PH_DATA;
                            s_d.cnt  = '0;
                            s_d.idx  = '0;
                            s_d.sh   = '0;
                            s_d.perr = 1'b0;
                            s_d.ferr = 1'b0;
                        end else begin
                            s_d.ph = PH_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (s_q.cnt != CW'(OSR-1)) begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end else begin
                        s_d.cnt = '0;
                        case (s_q.ph)
                            PH_DATA: begin
                                s_d.sh = {rxd, s_q.sh[DW-1:1]};
                                if (s_q.idx == last)
                                    s_d.ph = mode.par_en ? PH_PAR : PH_STOP;
                                else
                                    s_d.idx = s_q.idx + 1'b1;
                            end
                            PH_PAR: begin
                                s_d.perr = (rxd != calc_par(16'(aligned), mode.odd));
                                s_d.ph   = PH_STOP;
                            end
                            PH_STOP: begin
                                s_d.ferr = !rxd;
                                s_d.data = aligned;
                                s_d.done = 1'b1;
                                s_d.ph   = PH_IDLE;
                            end
                            default: s_d.ph = PH_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign data = s_q.data;
    assign perr = s_q.perr;
    assign ferr = s_q.ferr;
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int OSR       = 16,
    parameter int SYNC_STG  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          rxd,
    output logic          txd,
    output logic          irq_tx,
    output logic          irq_rx
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_MODE = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;
    localparam mode_t MODE_RST = mode_t'(4'b0001);

    typedef struct packed {
        logic [DW-1:0] rbuf;
        logic          full;
        logic          pe;
        logic          fe;
        logic          ov;
        mode_t         mode;
        logic          tx_ie;
        logic          rx_ie;
        logic          tx_flag;
        logic          irq_tx;
        logic          irq_rx;
    } regs_t;

    regs_t r_d, r_q;

    logic          rxd_s;
    logic          tx_start, tx_busy, tx_done;
    logic          rx_done, rx_perr, rx_ferr;
    logic [DW-1:0] rx_data;

    // Signals observed by the bound checker
    logic       rx_ie_w, rx_full_w, st_ov_w;
    logic [3:0] mode_w;

    uart_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    uart_tx #(.DW(DW), .OSR(OSR)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
        .data(wdata), .mode(r_q.mode), .busy(tx_busy), .txd(txd), .done(tx_done)
    );

    uart_rx #(.DW(DW), .OSR(OSR)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd_s), .mode(r_q.mode),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    assign tx_start = wr_en && (addr == A_DATA) && !tx_busy;

    always_comb begin
        r_d = r_q;
        r_d.irq_tx = 1'b0;
        r_d.irq_rx = 1'b0;

        if (wr_en && (addr == A_MODE) && !tx_busy)
            r_d.mode = mode_t'(wdata[3:0]);

        if (wr_en && (addr == A_CTRL)) begin
            r_d.tx_ie = wdata[0];
            r_d.rx_ie = wdata[1];
            if (wdata[2]) r_d.tx_flag = 1'b0;
        end

        if (tx_done) begin
            r_d.tx_flag = 1'b1;
            r_d.irq_tx  = r_d.tx_ie;
        end

        // A read counts before a frame completing in the same cycle
        if (rd_en && (addr == A_DATA)) begin
            r_d.full = 1'b0;
            r_d.pe   = 1'b0;
            r_d.fe   = 1'b0;
            r_d.ov   = 1'b0;
        end

        if (rx_done) begin
            if (r_d.full) begin
                r_d.ov = 1'b1;
            end else begin
                r_d.rbuf = rx_data;
                r_d.full = 1'b1;
            end
            r_d.pe     = rx_perr;
            r_d.fe     = rx_ferr;
            r_d.irq_rx = r_d.rx_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= MODE_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            A_DATA:  rdata = r_q.rbuf;
            A_STAT:  rdata = DW'({r_q.ov, r_q.fe, r_q.pe});
            A_MODE:  rdata = DW'(r_q.mode);
            default: rdata = DW'({r_q.tx_flag, r_q.rx_ie, r_q.tx_ie});
        endcase
    end

    assign irq_tx    = r_q.irq_tx;
    assign irq_rx    = r_q.irq_rx;
    assign rx_ie_w   = r_q.rx_ie;
    assign rx_full_w = r_q.full;
    assign st_ov_w   = r_q.ov;
    assign mode_w    = r_q.mode;
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_busy,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       rx_ie,
    input logic       rx_full,
    input logic       st_ov,
    input logic [3:0] mode
);
    // R1: line rests high whenever the transmitter is idle
    assert_txd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R3: transmit completion is a single-cycle pulse
    assert_irq_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);

    // R9: receive completion is a single-cycle pulse
    assert_irq_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);

    // R9: no receive pulse while the enable is off
    assert_irq_rx_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_ie);

    // R10: line format frozen while a frame is being sent
    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_busy) |-> $stable(mode));

    // R7: overrun only exists while the buffer is still unread
    assert_ov_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_ov |-> rx_full);
endmodule

bind uart_xcvr uart_xcvr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .rx_ie(rx_ie_w),
    .rx_full(rx_full_w), .st_ov(st_ov_w), .mode(mode_w)
);

// File: tb/uart_xcvr_tb_top.sv
module uart_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       rxd = 1'b1;
    logic [7:0] rdata;
    logic       txd, irq_tx, irq_rx;

    int n_cmp = 0;
    int n_bad = 0;
    int rx_irqs = 0;
    int tx_irqs = 0;

    uart_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    always #5 clk = ~clk;

    // One tick every 4 clocks -> 64 clocks per bit
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (irq_rx) rx_irqs++;
        if (irq_tx) tx_irqs++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(10 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic [3:0] m);
        logic [7:0] dm;
        dm = m[0] ? d : {1'b0, d[6:0]};
        return (^dm) ^ m[2];
    endfunction

    // Mode: bit0 8-bit, bit1 parity on, bit2 odd, bit3 two stop bits
    function automatic void build_frame(input logic [7:0] d, input logic [3:0] m,
                                        input logic bad_par, input logic bad_stop,
                                        output logic [11:0] b, output int n, output int stop_pos);
        b = '1;
        n = 0;
        b[n] = 1'b0; n = n + 1;
        for (int i = 0; i < (m[0] ? 8 : 7); i++) begin
            b[n] = d[i]; n = n + 1;
        end
        if (m[1]) begin
            b[n] = exp_par(d, m) ^ bad_par; n = n + 1;
        end
        stop_pos = n;
        b[n] = ~bad_stop; n = n + 1;
        if (m[3]) begin
            b[n] = 1'b1; n = n + 1;
        end
    endfunction

    // Write d, then sample txd near every bit centre (R2)
    task automatic send_tx(input logic [7:0] d, input logic [3:0] m, input logic intrude);
        logic [11:0] b;
        int n, sp;
        build_frame(d, m, 1'b0, 1'b0, b, n, sp);
        bus_write(2'd0, d);
        if (intrude) begin
            bus_write(2'd0, 8'hFF);   // R2: ignored while busy
            bus_write(2'd2, 8'h0F);   // R10: ignored while busy
            repeat (26) @(negedge clk);
        end else begin
            repeat (30) @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            check($sformatf("R2 tx bit %0d of 0x%0h", i, d), txd, b[i]);
            repeat (64) @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input logic [3:0] m,
                           input logic bad_par, input logic bad_stop);
        logic [11:0] b;
        int n, sp;
        build_frame(d, m, bad_par, bad_stop, b, n, sp);
        for (int i = 0; i < n; i++) begin
            rxd = b[i];
            if (i == sp && bad_stop) begin
                repeat (40) @(negedge clk);
                rxd = 1'b1;
                repeat (24) @(negedge clk);
            end else begin
                repeat (64) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int t0, r0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check("R1 txd", txd, 1'b1);
        check("R1 irq_tx", irq_tx, 1'b0);
        check("R1 irq_rx", irq_rx, 1'b0);
        bus_read(2'd1, v); check("R1 status", v, 8'h00);
        bus_read(2'd2, v); check("R1 mode", v, 8'h01);
        repeat (200) @(negedge clk);
        bus_read(2'd3, v); check("R1 ctrl no tx flag", v, 8'h00);
        check("R1 no tx irq", tx_irqs, 0);

        bus_write(2'd3, 8'h03);

        // R2/R3: directed frame in default format
        t0 = tx_irqs;
        send_tx(8'hA5, 4'h1, 1'b0);
        check("R3 irq_tx count", tx_irqs, t0 + 1);
        bus_read(2'd3, v); check("R3 tx flag set", v, 8'h07);
        bus_write(2'd3, 8'h07);
        bus_read(2'd3, v); check("R3 tx flag cleared", v, 8'h03);

        // R2/R10: writes during a frame are ignored
        t0 = tx_irqs;
        send_tx(8'h3C, 4'h1, 1'b1);
        repeat (100) @(negedge clk);
        check("R2 no second frame", txd, 1'b1);
        check("R2 one irq only", tx_irqs, t0 + 1);
        bus_read(2'd2, v); check("R10 mode unchanged", v, 8'h01);

        // R3: flag set with irq disabled, no pulse
        bus_write(2'd3, 8'h06);
        t0 = tx_irqs;
        send_tx(8'h81, 4'h1, 1'b0);
        check("R3 masked irq_tx", tx_irqs, t0);
        bus_read(2'd3, v); check("R3 flag w/o enable", v, 8'h06);
        bus_write(2'd3, 8'h07);

        // R2: random formats
        for (int k = 0; k < 6; k++) begin
            logic [3:0] m;
            logic [7:0] d;
            m = 4'($urandom % 16);
            d = 8'($urandom);
            bus_write(2'd2, {4'h0, m});
            t0 = tx_irqs;
            send_tx(d, m, 1'b0);
            check("R3 random irq_tx", tx_irqs, t0 + 1);
        end

        // R4/R9: clean receive
        bus_write(2'd2, 8'h01);
        r0 = rx_irqs;
        send_rx(8'h5A, 4'h1, 1'b0, 1'b0);
        check("R9 irq_rx", rx_irqs, r0 + 1);
        bus_read(2'd1, v); check("R4 status clean", v, 8'h00);
        bus_read(2'd0, v); check("R4 data", v, 8'h5A);

        // R4: 7-bit mode, bit7 not received
        bus_write(2'd2, 8'h00);
        send_rx(8'hFF, 4'h0, 1'b0, 1'b0);
        bus_read(2'd0, v); check("R4 7-bit data", v, 8'h7F);

        // R5: parity error, even then odd
        bus_write(2'd2, 8'h03);
        send_rx(8'h33, 4'h3, 1'b1, 1'b0);
        bus_read(2'd1, v); check("R5 even parity error", v, 8'h01);
        bus_read(2'd0, v); check("R5 data kept", v, 8'h33);
        bus_write(2'd2, 8'h07);
        send_rx(8'h34, 4'h7, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R5 odd parity ok", v, 8'h00);
        bus_read(2'd0, v);

        // R6/R9: framing error still interrupts
        bus_write(2'd2, 8'h01);
        r0 = rx_irqs;
        send_rx(8'hC3, 4'h1, 1'b0, 1'b1);
        check("R9 irq on error frame", rx_irqs, r0 + 1);
        bus_read(2'd1, v); check("R6 framing error", v, 8'h02);
        bus_read(2'd0, v); check("R6 data", v, 8'hC3);
        bus_read(2'd1, v); check("R8 status cleared by read", v, 8'h00);

        // R7/R8: overrun, persistence and clear
        send_rx(8'h11, 4'h1, 1'b0, 1'b0);
        send_rx(8'h22, 4'h1, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R7 overrun", v, 8'h04);
        send_rx(8'h44, 4'h1, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R7 overrun persists", v, 8'h04);
        bus_read(2'd0, v); check("R7 older data kept", v, 8'h11);
        bus_read(2'd1, v); check("R8 clear after read", v, 8'h00);
        send_rx(8'h55, 4'h1, 1'b0, 1'b1);
        bus_read(2'd1, v); check("R8 next frame sets fe", v, 8'h02);
        send_rx(8'h66, 4'h1, 1'b0, 1'b0);
        bus_read(2'd1, v); check("R8 next frame replaces fe", v, 8'h04);
        bus_read(2'd0, v); check("R8 buffer", v, 8'h55);

        // R9: disabled receive interrupt
        bus_write(2'd3, 8'h01);
        r0 = rx_irqs;
        send_rx(8'h77, 4'h1, 1'b0, 1'b0);
        check("R9 masked irq_rx", rx_irqs, r0);
        bus_read(2'd0, v); check("R9 data still received", v, 8'h77);
        bus_write(2'd3, 8'h03);

        // R11: short glitch rejected
        r0 = rx_irqs;
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (900) @(negedge clk);
        check("R11 no irq from glitch", rx_irqs, r0);
        bus_read(2'd1, v); check("R11 status untouched", v, 8'h00);
        bus_read(2'd0, v); check("R11 buffer untouched", v, 8'h77);

        // Random receive frames
        for (int k = 0; k < 10; k++) begin
            logic [3:0] m;
            logic [7:0] d;
            logic bp, bs;
            m  = 4'($urandom % 16);
            d  = 8'($urandom);
            bp = m[1] & 1'($urandom);
            bs = (($urandom % 4) == 0);
            bus_write(2'd2, {4'h0, m});
            r0 = rx_irqs;
            send_rx(d, m, bp, bs);
            check("R9 random irq_rx", rx_irqs, r0 + 1);
            bus_read(2'd1, v); check("R5 R6 random status", v, {6'd0, bs, bp});
            bus_read(2'd0, v); check("R4 random data", v, m[0] ? d : {1'b0, d[6:0]});
        end

        summary();
        $finish;
    end
endmodule